// File: doc/BRIEF.md
# SDRAM Refresh Timer and Sequencer

This block produces the refresh traffic that a synchronous DRAM controller has to issue. A free-running prescaler offers seven divided ticks. A clock-select field picks one of them to advance an up-counter. Each time the incremented count equals a programmed constant, the counter returns to zero and a burst of auto-refresh commands is queued. The size of the burst comes from a repeat field. The command sequencer takes the commands one at a time through a request/acknowledge pair.

Two mode bits choose between idle, periodic auto-refresh and self-refresh. In self-refresh the block asks the sequencer to place the memory in its low-power retention state and waits for a done strobe. When the mode is left, it asks for the exit, waits for done, and then resumes periodic work with the counter cleared. Software writes the constant, the counter and the mode bits first, and the clock-select and repeat fields last, so that counting starts from a known point.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: The counter advances only while enable (address 0 bit 0) is 1, self mode (address 0 bit 1) is 0 and the clock-select field (address 3 bits 2:0) is nonzero. For select values 1 to 7 it advances once every 4, 16, 64, 256, 1024, 2048 or 4096 clocks. The first step comes that many clocks after the write to address 3.
- R2: Select value 0 freezes the counter. Selecting a clock again resumes counting from the held value. A write to address 2 loads the counter directly.
- R3: When the incremented count equals the constant (address 1), the counter becomes 0 on that same edge and refresh requests begin on the next cycle.
- R4: Repeat field values (address 3 bits 5:3) 0, 1, 2, 3 and 4 queue 1, 2, 4, 6 and 8 refreshes per match. Values 5 to 7 queue 8.
- R5: The refresh request stays high until every queued refresh has been acknowledged, one per acknowledge cycle. An acknowledge with no request pending has no effect.
- R6: A match that occurs while refreshes are still queued sets a sticky overflow flag and is discarded. This includes a match in the same cycle as the last acknowledge. Writing 0 to address 0 bit 2 clears the flag, and writing 1 to it leaves the flag unchanged.
- R7: With enable and self mode both 1, the block first waits for the queue to drain, then raises the self-refresh entry request until done. While in self-refresh the counter is frozen and no refresh request is raised.
- R8: Clearing self mode or enable during self-refresh raises the exit request until done. On that done the counter is cleared and periodic operation resumes.
- R9: After reset the counter, flag and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 constant, 2 counter, 3 select/repeat |
| regWrData | input | CNT_W | Register write data |
| refAck | input | 1 | Sequencer accepted one refresh |
| selfDone | input | 1 | Sequencer finished self-refresh entry or exit |
| refReq | output | 1 | Refresh request, held while refreshes are queued |
| selfEnterReq | output | 1 | Self-refresh entry request |
| selfExitReq | output | 1 | Self-refresh exit request |
| ovfFlag | output | 1 | Sticky overflow flag |
| cntValue | output | CNT_W | Current counter value |

## Verification
A compare match and the acknowledge of the last queued refresh can land on the same clock edge. The question is then whether the new burst is added or lost. The bench arranges a one-refresh burst and withholds the acknowledge until the cycle before the next match is due, so both are sampled on one edge. It expects the request to drop and the overflow flag to rise. A separate case acknowledges in a cycle with no match and expects the flag to stay clear.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  localparam int MAX_DIV_LOG = 12;
  localparam int PEND_W = 4;

  typedef struct packed {
    logic run;
    logic clr;
    logic ld;
    logic preClr;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SELF  = 2'd2,
    ST_EXIT  = 2'd3
  } srState_t;

  // log2 of the divide ratio for a select value (0 unused)
  function automatic int divLog(input int sel);
    case (sel)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic logic [PEND_W-1:0] burstLen(input logic [2:0] rep);
    case (rep)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = MAX_DIV_LOG
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [2:0]       clkSel,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] ldVal,
  output logic [CNT_W-1:0] cntQ,
  output logic             matchPulse
);

  logic [PRE_W-1:0] preCnt;
  logic [7:0]       tickVec;
  logic             tick;
  logic [CNT_W-1:0] cntInc;

  always_ff @(posedge clk) begin
    if (!rstN)           preCnt <= '0;
    else if (stb.preClr) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  assign tickVec[0] = 1'b0;
  for (genvar g = 1; g < 8; g++) begin : g_tap
    assign tickVec[g] = &preCnt[divLog(g)-1:0];
  end

  assign tick       = stb.run && tickVec[clkSel];
  assign cntInc     = cntQ + 1'b1;
  assign matchPulse = tick && !stb.ld && !stb.clr && (cntInc == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN)          cntQ <= '0;
    else if (stb.clr)   cntQ <= '0;
    else if (stb.ld)    cntQ <= ldVal;
    else if (matchPulse) cntQ <= '0;
    else if (tick)      cntQ <= cntInc;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.ld && !stb.clr) |=> $stable(cntQ));

  // R3
  match_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> (cntQ == '0));

endmodule

// File: rtl/refresh_control.sv
module refresh_control
  import refresh_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             matchIn,
  input  logic             refAck,
  input  logic             selfDone,
  output dpStrobe_t        stb,
  output logic [2:0]       clkSel,
  output logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] ldVal,
  output logic             refReq,
  output logic             selfEnterReq,
  output logic             selfExitReq,
  output logic             ovfFlag
);

  logic             enQ, selfQ, ovfQ;
  logic [CNT_W-1:0] cmpQ;
  logic [2:0]       selQ, repQ;
  logic [PEND_W-1:0] pendQ, pendD;
  srState_t         stateQ, stateD;
  logic             wrCtrl, wrCmp, wrCnt, wrSel;
  logic             ackOk, selfWanted;

  assign wrCtrl = regWrEn && (regAddr == 2'd0);
  assign wrCmp  = regWrEn && (regAddr == 2'd1);
  assign wrCnt  = regWrEn && (regAddr == 2'd2);
  assign wrSel  = regWrEn && (regAddr == 2'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      selfQ <= 1'b0;
      cmpQ  <= '0;
      selQ  <= '0;
      repQ  <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= regWrData[0];
        selfQ <= regWrData[1];
      end
      if (wrCmp) cmpQ <= regWrData;
      if (wrSel) begin
        selQ <= regWrData[2:0];
        repQ <= regWrData[5:3];
      end
    end
  end

  // refresh queue
  assign ackOk = refAck && (pendQ != '0);

  always_comb begin
    pendD = pendQ;
    if (matchIn && (pendQ == '0)) pendD = burstLen(repQ);
    else if (ackOk)               pendD = pendQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             ovfQ <= 1'b0;
    else if (matchIn && (pendQ != '0))     ovfQ <= 1'b1;
    else if (wrCtrl && !regWrData[2])      ovfQ <= 1'b0;
  end

  // self-refresh sequencing
  assign selfWanted = enQ && selfQ;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_RUN:   if (selfWanted && (pendQ == '0)) stateD = ST_ENTER;
      ST_ENTER: if (selfDone) stateD = ST_SELF;
      ST_SELF:  if (!selfWanted) stateD = ST_EXIT;
      ST_EXIT:  if (selfDone) stateD = ST_RUN;
      default:  stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb.run    = (stateQ == ST_RUN) && enQ && !selfQ && (selQ != 3'd0);
    stb.clr    = (stateQ == ST_EXIT) && selfDone;
    stb.ld     = wrCnt;
    stb.preClr = wrSel;
  end

  assign clkSel       = selQ;
  assign cmpVal       = cmpQ;
  assign ldVal        = regWrData;
  assign refReq       = (pendQ != '0);
  assign selfEnterReq = (stateQ == ST_ENTER);
  assign selfExitReq  = (stateQ == ST_EXIT);
  assign ovfFlag      = ovfQ;

  // R5
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!refReq && !matchIn) |=> !refReq);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refAck) |=> refReq);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(matchIn && refReq));

  // R7
  self_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selfEnterReq, selfExitReq, refReq}));

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             refAck,
  input  logic             selfDone,
  output logic             refReq,
  output logic             selfEnterReq,
  output logic             selfExitReq,
  output logic             ovfFlag,
  output logic [CNT_W-1:0] cntValue
);

  dpStrobe_t        stb;
  logic [2:0]       clkSel;
  logic [CNT_W-1:0] cmpVal, ldVal;
  logic             matchPulse;

  refresh_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .matchIn(matchPulse), .refAck(refAck), .selfDone(selfDone),
    .stb(stb), .clkSel(clkSel), .cmpVal(cmpVal), .ldVal(ldVal),
    .refReq(refReq), .selfEnterReq(selfEnterReq),
    .selfExitReq(selfExitReq), .ovfFlag(ovfFlag)
  );

  refresh_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .clkSel(clkSel),
    .cmpVal(cmpVal), .ldVal(ldVal),
    .cntQ(cntValue), .matchPulse(matchPulse)
  );

endmodule

// File: tb/sdram_refresh_ctrl_tb.sv
module sdram_refresh_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [CNT_W-1:0] regWrData = '0;
  logic manualAck = 1'b0;
  logic autoAckQ = 1'b0;
  logic autoAck = 1'b0;
  logic refAck;
  logic selfDone = 1'b0;
  logic refReq, selfEnterReq, selfExitReq, ovfFlag;
  logic [CNT_W-1:0] cntValue;

  int errors = 0;
  int checks = 0;
  int ackCount = 0;
  bit done = 1'b0;

  assign refAck = manualAck | autoAckQ;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .refAck(refAck), .selfDone(selfDone),
    .refReq(refReq), .selfEnterReq(selfEnterReq), .selfExitReq(selfExitReq),
    .ovfFlag(ovfFlag), .cntValue(cntValue)
  );

  // an ack asserted here is always consumed at the next edge
  always @(negedge clk) begin
    autoAckQ <= autoAck && refReq;
    if (autoAck && refReq) ackCount++;
  end

  function automatic int divOf(input int sel);
    case (sel)
      1: return 4;
      2: return 16;
      3: return 64;
      4: return 256;
      5: return 1024;
      6: return 2048;
      default: return 4096;
    endcase
  endfunction

  function automatic int burstOf(input int rep);
    case (rep)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regWrEn = 1'b1;
    regAddr = a[1:0];
    regWrData = d[CNT_W-1:0];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    autoAck = 1'b0;
    manualAck = 1'b0;
    selfDone = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic startTimer(input int cmp, input int cnt, input int ctrl,
                            input int sel, input int rep);
    wr(1, cmp);
    wr(2, cnt);
    wr(0, ctrl);
    wr(3, (rep << 3) | sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'd2024);
    @(negedge clk);
    doReset();

    // R9 reset state
    check("R9 cnt", cntValue, 0);
    check("R9 req", {refReq, selfEnterReq, selfExitReq, ovfFlag}, 0);

    // R1/R3 divide-by-4 counting and match
    startTimer(3, 0, 1, 1, 0);
    cyc(4); check("R1 div4 step1", cntValue, 1);
    cyc(4); check("R1 div4 step2", cntValue, 2);
    cyc(3); check("R3 pre-match", refReq, 0);
    cyc(1); check("R3 cnt cleared", cntValue, 0);
    check("R3 req raised", refReq, 1);
    // R5 held until ack
    cyc(5); check("R5 req held", refReq, 1);
    manualAck = 1'b1; cyc(1); manualAck = 1'b0;
    check("R5 req dropped", refReq, 0);
    check("R6 no ovf on plain ack", ovfFlag, 0);
    // R5 ack with nothing queued
    manualAck = 1'b1; cyc(2); manualAck = 1'b0;
    check("R5 stray ack", refReq, 0);

    // R1 disabled: no counting
    doReset();
    startTimer(200, 0, 0, 1, 0);
    cyc(20); check("R1 disabled", cntValue, 0);

    // R1 divide-by-16
    doReset();
    startTimer(200, 0, 1, 2, 0);
    cyc(15); check("R1 div16 before", cntValue, 0);
    cyc(1);  check("R1 div16 at", cntValue, 1);

    // R1 divide-by-4096
    doReset();
    startTimer(200, 0, 1, 7, 0);
    cyc(4095); check("R1 div4096 before", cntValue, 0);
    cyc(1);    check("R1 div4096 at", cntValue, 1);

    // R2 freeze and resume
    doReset();
    startTimer(200, 5, 1, 1, 0);
    check("R2 load", cntValue, 5);
    cyc(4); check("R2 counting", cntValue, 6);
    wr(3, 0);
    cyc(30); check("R2 frozen", cntValue, 6);
    wr(3, 1);
    cyc(3); check("R2 resume held", cntValue, 6);
    cyc(1); check("R2 resume step", cntValue, 7);

    // R4 every repeat encoding
    for (int rep = 0; rep < 8; rep++) begin
      doReset();
      autoAck = 1'b1;
      ackCount = 0;
      startTimer(4, 0, 1, 1, rep);
      cyc(16 + 10);
      check($sformatf("R4 burst rep=%0d", rep), ackCount, burstOf(rep));
      check("R6 no ovf in burst", ovfFlag, 0);
    end

    // R6 overflow, write-1 no effect, write-0 clears
    doReset();
    startTimer(1, 0, 1, 1, 4);
    cyc(4); check("R6 first burst", refReq, 1);
    check("R6 flag low", ovfFlag, 0);
    cyc(4); check("R6 ovf set", ovfFlag, 1);
    wr(0, 4);
    check("R6 write1 keeps", ovfFlag, 1);
    wr(0, 0);
    check("R6 write0 clears", ovfFlag, 0);
    manualAck = 1'b1; cyc(7); manualAck = 1'b0;
    check("R6 burst discarded", refReq, 1);
    manualAck = 1'b1; cyc(1); manualAck = 1'b0;
    check("R6 drained at 8", refReq, 0);

    // R6 match and last ack on the same edge
    doReset();
    startTimer(1, 0, 1, 1, 0);
    cyc(4); check("R6 coll req", refReq, 1);
    cyc(3);
    manualAck = 1'b1; cyc(1); manualAck = 1'b0;
    check("R6 coll req dropped", refReq, 0);
    check("R6 coll ovf", ovfFlag, 1);

    // R7 entry waits for queue, R8 exit clears counter
    doReset();
    startTimer(1, 0, 1, 1, 1);
    cyc(4); check("R7 queued", refReq, 1);
    wr(0, 3);
    cyc(2); check("R7 waits drain", selfEnterReq, 0);
    manualAck = 1'b1; cyc(2); manualAck = 1'b0;
    check("R7 drained", refReq, 0);
    cyc(1); check("R7 enter req", selfEnterReq, 1);
    cyc(3); check("R7 enter held", selfEnterReq, 1);
    selfDone = 1'b1; cyc(1); selfDone = 1'b0;
    check("R7 enter done", selfEnterReq, 0);
    wr(2, 7);
    cyc(40); check("R7 frozen", cntValue, 7);
    check("R7 no refresh", refReq, 0);
    wr(0, 1);
    check("R8 not yet", selfExitReq, 0);
    cyc(1); check("R8 exit req", selfExitReq, 1);
    cyc(2); check("R8 exit held", selfExitReq, 1);
    selfDone = 1'b1; cyc(1); selfDone = 1'b0;
    check("R8 exit done", selfExitReq, 0);
    check("R8 cnt cleared", cntValue, 0);
    cyc(4); check("R8 periodic again", refReq, 1);

    // random bursts with automatic acknowledge
    for (int it = 0; it < 30; it++) begin
      int cmp, sel, rep, per;
      cmp = 3 + int'($urandom_range(3));
      sel = 1 + int'($urandom_range(1));
      rep = int'($urandom_range(7));
      per = divOf(sel) * cmp;
      doReset();
      autoAck = 1'b1;
      ackCount = 0;
      startTimer(cmp, 0, 1, sel, rep);
      cyc(3 * per + 9);
      check($sformatf("R4 rand acks it=%0d", it), ackCount, 3 * burstOf(rep));
      check("R6 rand no ovf", ovfFlag, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule